// File: doc/BRIEF.md
# Interrupt Mapping and Concentrator Unit

This block collects level-sensitive interrupt lines from two groups of sources, the PCI slot lines and the on-board I/O lines, and presents each one as a request on a single flat vector bus toward a processor. Each vector position stands for one interrupt number. A PCI slot source at index `s` drives vector `s`. An on-board source `k` drives vector `0x20 + k`. A line reaches its vector only while the map register that governs it has its enable bit set. Otherwise the vector is held low.

Map registers sit in two banks behind a simple register port. Writes are synchronous and reads are combinational. Every map register also carries a group field and an interrupt-number field. Together these two fields form the vector identity. They are preset at reset and cannot be changed by software.

A small fixed translation folds a handful of legacy ISA lines onto on-board vector numbers. These translated lines are ORed into the matching on-board source ahead of the enable gate, so they obey that source's map register.

Top module: `irq_concentrator`

## Requirements
- R1: After reset, PCI map register n (0..7) reads `(0x1F<<6)|(n<<2)` and on-board map register k (0..31) reads `(0x1F<<6)|(0x20+k)`. Bit 31 (enable) is clear in every map register, so `vec_req` is all zeros.
- R2: PCI map register n is accessed at address `0x0C00 + 8*n + 4`. It governs the PCI sources `4n` to `4n+3`, so source s uses register `s/4`.
- R3: On-board map register k is accessed at address `0x1000 + 8*k + 4`, with the index taken from address bits [7:3]. It governs on-board source k, which drives vector `0x20+k`.
- R4: A register write keeps the protected field [10:0] (group in [10:6], interrupt number in [5:0]) of the current value. It takes bits [31:11] from the write data.
- R5: An access with address bit 2 clear reaches no map register. A read returns zero and a write leaves every register unchanged.
- R6: While a source's enable bit 31 is set, its vector output equals the source level in the same cycle. While the bit is clear, the vector output is 0.
- R7: Legacy line 1 maps to vector 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. Each mapped line is ORed into that on-board source before the enable gate. All other legacy lines have no effect on any vector.
- R8: The vector bus is 64 bits wide. It carries on-board vectors 0x30 (bus error, source 16) and 0x32 (wakeup, source 18) like any other on-board source. Reads of any other address return zero.
- R9: A write is visible on the read data and on the vectors after the next rising clock edge. The read data follows the address with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_lvl | input | 32 | PCI slot source levels |
| obio_lvl | input | 32 | On-board source levels |
| isa_lvl | input | 16 | Legacy ISA line levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| vec_req | output | 64 | Interrupt-vector request per vector number |

## Verification
Random source levels are applied under random enable patterns across both banks. This separates a fault in the four-to-one sharing of PCI registers from a fault in the one-to-one on-board indexing. Random write data with all ones in the protected field shows whether the write merge keeps the preset identity bits. Addresses with bit 2 cleared show whether the decoder ignores that bit. Directed legacy-line cases drive each of the five mapped lines and the unmapped lines with their target enabled or blocked, and so tell translation faults apart from gating faults.

// File: rtl/irq_concentrator_pkg.sv
package irq_concentrator_pkg;
   localparam int REG_W     = 32;
   localparam int EN_BIT    = 31;
   localparam int INO_W     = 6;
   localparam int GRP_W     = 5;
   localparam int PROT_W    = INO_W + GRP_W;
   localparam int ISA_LINES = 16;

   typedef logic [REG_W-1:0] map_reg_t;

   // preset identity value: group all ones, interrupt number given
   function automatic map_reg_t map_preset(int ino);
      map_reg_t v;
      v = '0;
      v[PROT_W-1:INO_W] = '1;
      v[INO_W-1:0]      = INO_W'(ino);
      return v;
   endfunction

   // legacy line to vector number, -1 when the line is dropped
   function automatic int isa_target(int line);
      case (line)
         1:  return 'h29;
         4:  return 'h2b;
         6:  return 'h27;
         7:  return 'h22;
         12: return 'h2a;
         default: return -1;
      endcase
   endfunction

   // set of legacy lines that land on a given vector number
   function automatic logic [ISA_LINES-1:0] isa_lines_for(int vec);
      logic [ISA_LINES-1:0] m;
      m = '0;
      for (int l = 0; l < ISA_LINES; l++)
         if (isa_target(l) == vec) m[l] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/imc_map_bank.sv
module imc_map_bank
   import irq_concentrator_pkg::*;
#(
   parameter int N        = 8,
   parameter int IDX_W    = 3,
   parameter int INO_BASE = 0,
   parameter int INO_STEP = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_hit,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [REG_W-1:0]       wr_data,
   output logic [N-1:0][REG_W-1:0] map_q
);
   localparam logic [REG_W-1:0] PROT_MASK = {{(REG_W-PROT_W){1'b0}}, {PROT_W{1'b1}}};

   if (N > (1 << IDX_W)) begin : g_bad_depth
      $error("imc_map_bank: N exceeds index range");
   end

   for (genvar i = 0; i < N; i++) begin : g_reg
      localparam map_reg_t RST = map_preset(INO_BASE + i * INO_STEP);
      always_ff @(posedge clk) begin
         if (!rst_n)
            map_q[i] <= RST;
         else if (wr_hit && (int'(wr_idx) == i))
            map_q[i] <= (map_q[i] & PROT_MASK) | (wr_data & ~PROT_MASK);
      end

      // R4: the identity field never moves once out of reset
      a_r4_prot_kept: assert property (@(posedge clk) disable iff (!rst_n)
         $stable(map_q[i][PROT_W-1:0]));
   end
endmodule

// File: rtl/imc_gate.sv
module imc_gate
   import irq_concentrator_pkg::*;
#(
   parameter int NSRC    = 32,
   parameter int PER_REG = 4,
   localparam int NREG   = NSRC / PER_REG
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           src,
   input  logic [NREG-1:0][REG_W-1:0] map_q,
   output logic [NSRC-1:0]           vec
);
   if (NSRC % PER_REG != 0) begin : g_bad_share
      $error("imc_gate: NSRC must be a multiple of PER_REG");
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign vec[s] = src[s] & map_q[s / PER_REG][EN_BIT];

      // R6: a blocked source never raises its vector
      a_r6_blocked_low: assert property (@(posedge clk) disable iff (!rst_n)
         !map_q[s / PER_REG][EN_BIT] |-> !vec[s]);
      // R6: an enabled source passes its level unchanged
      a_r6_enabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
         map_q[s / PER_REG][EN_BIT] |-> (vec[s] == src[s]));
   end
endmodule

// File: rtl/imc_isa_fold.sv
module imc_isa_fold
   import irq_concentrator_pkg::*;
#(
   parameter int N_OB    = 32,
   parameter int VEC_OFS = 32
) (
   input  logic [N_OB-1:0]      obio_lvl,
   input  logic [ISA_LINES-1:0] isa_lvl,
   output logic [N_OB-1:0]      ob_src
);
   for (genvar k = 0; k < N_OB; k++) begin : g_fold
      localparam logic [ISA_LINES-1:0] HITS = isa_lines_for(VEC_OFS + k);
      if (HITS == '0) begin : g_plain
         assign ob_src[k] = obio_lvl[k];
      end else begin : g_merge
         assign ob_src[k] = obio_lvl[k] | (|(isa_lvl & HITS));
      end
   end
endmodule

// File: rtl/irq_concentrator.sv
module irq_concentrator
   import irq_concentrator_pkg::*;
#(
   parameter int          N_PCI_REG = 8,
   parameter int          PCI_SHARE = 4,
   parameter int          N_OB      = 32,
   parameter logic [15:0] PCI_BASE  = 16'h0C00,
   parameter logic [15:0] OB_BASE   = 16'h1000,
   localparam int         N_PCI     = N_PCI_REG * PCI_SHARE,
   localparam int         NVEC      = N_PCI + N_OB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PCI-1:0]  pci_lvl,
   input  logic [N_OB-1:0]   obio_lvl,
   input  logic [15:0]       isa_lvl,
   input  logic              reg_wr,
   input  logic [15:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NVEC-1:0]   vec_req
);
   localparam int PCI_IDX_W = $clog2(N_PCI_REG);
   localparam int OB_IDX_W  = 5;

   if (NVEC < 'h33) begin : g_bad_span
      $error("irq_concentrator: vector space must reach 0x32");
   end
   if (N_OB > (1 << OB_IDX_W)) begin : g_bad_ob
      $error("irq_concentrator: too many on-board sources");
   end

   logic                 sel_word;
   logic                 pci_win, ob_win, ob_in_range;
   logic [PCI_IDX_W-1:0] pci_idx;
   logic [OB_IDX_W-1:0]  ob_idx;
   logic [N_PCI_REG-1:0][REG_W-1:0] pci_q;
   logic [N_OB-1:0][REG_W-1:0]      ob_q;
   logic [N_OB-1:0]                 ob_src;

   assign sel_word    = reg_addr[2];
   assign pci_win     = reg_addr[15:3+PCI_IDX_W] == PCI_BASE[15:3+PCI_IDX_W];
   assign pci_idx     = reg_addr[3+PCI_IDX_W-1:3];
   assign ob_win      = reg_addr[15:8] == OB_BASE[15:8];
   assign ob_idx      = reg_addr[7:3];
   assign ob_in_range = int'(ob_idx) < N_OB;

   imc_map_bank #(
      .N(N_PCI_REG), .IDX_W(PCI_IDX_W), .INO_BASE(0), .INO_STEP(PCI_SHARE)
   ) u_pci_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(reg_wr && sel_word && pci_win),
      .wr_idx(pci_idx), .wr_data(reg_wdata), .map_q(pci_q)
   );

   imc_map_bank #(
      .N(N_OB), .IDX_W(OB_IDX_W), .INO_BASE(N_PCI), .INO_STEP(1)
   ) u_ob_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(reg_wr && sel_word && ob_win && ob_in_range),
      .wr_idx(ob_idx), .wr_data(reg_wdata), .map_q(ob_q)
   );

   always_comb begin
      reg_rdata = '0;
      if (sel_word && pci_win)
         reg_rdata = pci_q[pci_idx];
      else if (sel_word && ob_win && ob_in_range)
         reg_rdata = ob_q[ob_idx];
   end

   imc_isa_fold #(.N_OB(N_OB), .VEC_OFS(N_PCI)) u_fold (
      .obio_lvl(obio_lvl), .isa_lvl(isa_lvl), .ob_src(ob_src)
   );

   imc_gate #(.NSRC(N_PCI), .PER_REG(PCI_SHARE)) u_pci_gate (
      .clk(clk), .rst_n(rst_n), .src(pci_lvl), .map_q(pci_q),
      .vec(vec_req[N_PCI-1:0])
   );

   imc_gate #(.NSRC(N_OB), .PER_REG(1)) u_ob_gate (
      .clk(clk), .rst_n(rst_n), .src(ob_src), .map_q(ob_q),
      .vec(vec_req[NVEC-1:N_PCI])
   );

   // R5: a write with the word-select bit clear changes no register
   a_r5_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr[2]) |=> ($stable(pci_q) && $stable(ob_q)));
   // R5: a read with the word-select bit clear returns zero
   a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_addr[2] |-> (reg_rdata == '0));
   // R1: no vector is raised in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (vec_req == '0));
   // R9: a write with no other write pending is visible one edge later
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[2] && pci_win) |=> (pci_q[$past(pci_idx)][31:11] == $past(reg_wdata[31:11])));
endmodule

// File: tb/irq_concentrator_test.sv
module irq_concentrator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pci_lvl = '0;
   logic [31:0] obio_lvl = '0;
   logic [15:0] isa_lvl = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] vec_req;

   int checks = 0;
   int errors = 0;
   logic [31:0] pm [8];
   logic [31:0] om [32];

   always #4 clk = ~clk;

   irq_concentrator uut (
      .clk(clk), .rst_n(rst_n), .pci_lvl(pci_lvl), .obio_lvl(obio_lvl),
      .isa_lvl(isa_lvl), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_req(vec_req)
   );

   function automatic logic [31:0] preset(int ino);
      return 32'((32'h1f << 6) | ino);
   endfunction

   function automatic logic [63:0] exp_vec();
      logic [63:0] v;
      logic [31:0] ob;
      ob = obio_lvl;
      if (isa_lvl[1])  ob[9]  = 1'b1;
      if (isa_lvl[4])  ob[11] = 1'b1;
      if (isa_lvl[6])  ob[7]  = 1'b1;
      if (isa_lvl[7])  ob[2]  = 1'b1;
      if (isa_lvl[12]) ob[10] = 1'b1;
      for (int s = 0; s < 32; s++) v[s] = pci_lvl[s] & pm[s/4][31];
      for (int k = 0; k < 32; k++) v[32+k] = ob[k] & om[k][31];
      return v;
   endfunction

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_vec(string req);
      logic [63:0] e;
      e = exp_vec();
      checks++;
      if (vec_req !== e) begin
         errors++;
         $display("FAIL %s: vec got %h expected %h", req, vec_req, e);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
      if (a[2] && a[15:6] == 10'h030)
         pm[a[5:3]] = (pm[a[5:3]] & 32'h7ff) | (d & ~32'h7ff);
      else if (a[2] && a[15:8] == 8'h10)
         om[a[7:3]] = (om[a[7:3]] & 32'h7ff) | (d & ~32'h7ff);
      @(negedge clk);
   endtask

   task automatic rd_check(string req, logic [15:0] a, logic [31:0] exp);
      reg_addr = a;
      #1 check32(req, reg_rdata, exp);
   endtask

   function automatic logic [15:0] pa(int n);
      return 16'h0c00 | 16'(n << 3) | 16'h4;
   endfunction
   function automatic logic [15:0] oa(int k);
      return 16'h1000 | 16'(k << 3) | 16'h4;
   endfunction

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int n = 0; n < 8; n++) pm[n] = preset(n << 2);
      for (int k = 0; k < 32; k++) om[k] = preset(32 + k);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R1 reset contents and quiet vectors
      pci_lvl = '1; obio_lvl = '1; isa_lvl = '1;
      #1 check_vec("R1 vectors after reset");
      for (int n = 0; n < 8; n++) rd_check("R1 pci preset", pa(n), preset(n << 2));
      for (int k = 0; k < 32; k++) rd_check("R1 onboard preset", oa(k), preset(32 + k));

      // R4 protected field survives an all-ones write
      wr(pa(3), 32'hffff_ffff);
      rd_check("R4 protect pci", pa(3), 32'hffff_f800 | preset(12));
      wr(oa(5), 32'h0000_0000);
      rd_check("R4 protect onboard", oa(5), preset(37));

      // R2 shared register gates four PCI sources
      pci_lvl = 32'h0000_f000; obio_lvl = '0; isa_lvl = '0;
      #1 check_vec("R2 pci sharing");
      check32("R2 vec bits 15:12", 32'(vec_req[15:12]), 32'hf);
      check32("R2 neighbours low", 32'(vec_req[11:8]), 32'h0);

      // R5 bit 2 clear: read zero and write ignored
      rd_check("R5 read bit2 clear", 16'h0c18, 32'h0);
      wr(16'h0c20, 32'h8000_0000);
      rd_check("R5 write ignored", pa(4), preset(16));
      wr(16'h1048, 32'h8000_0000);
      rd_check("R5 onboard write ignored", oa(9), preset(41));
      rd_check("R8 unmapped address", 16'h2004, 32'h0);

      // R7 legacy translation with target enabled
      wr(oa(9), 32'h8000_0000);
      obio_lvl = '0; pci_lvl = '0; isa_lvl = 16'h0002;
      #1 check32("R7 line1 to 0x29", 32'(vec_req[8'h29]), 32'h1);
      check_vec("R7 line1 vector set");
      isa_lvl = 16'hefff & ~16'h10d2;
      #1 check32("R7 unmapped lines dropped", 32'(|vec_req), 32'h0);
      for (int k = 0; k < 32; k++) wr(oa(k), 32'h8000_0000);
      isa_lvl = 16'h10d2;
      #1 check_vec("R7 all mapped lines");
      check32("R7 mapped set", 32'(vec_req[63:32]), 32'h0000_0e84);
      isa_lvl = 16'hef2d;
      #1 check32("R7 others dropped all enabled", 32'(vec_req[63:32]), 32'h0);

      // R8 bus error and wakeup vectors
      isa_lvl = '0; obio_lvl = 32'h0005_0000;
      #1 check32("R8 vectors 0x30 0x32", 32'(vec_req[63:48]), 32'h0005);

      // R9 write lands after the clock edge, read is combinational
      reg_addr = pa(6); reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
      pci_lvl = 32'h0100_0000;
      #1 check32("R9 not before edge", 32'(vec_req[24]), 32'h0);
      @(posedge clk); #1 reg_wr = 1'b0;
      pm[6] = 32'h8000_0000 | preset(24);
      check32("R9 visible after edge", reg_rdata, pm[6]);
      check_vec("R9 vector after edge");

      // R6 and R3 random stimulus
      for (int it = 0; it < 300; it++) begin
         logic [15:0] a;
         logic [31:0] d;
         int r;
         r = int'($urandom_range(0, 3));
         d = $urandom;
         if (r == 0)      a = pa(int'($urandom_range(0, 7)));
         else if (r == 1) a = oa(int'($urandom_range(0, 31)));
         else if (r == 2) a = pa(int'($urandom_range(0, 7))) & ~16'h4;
         else             a = oa(int'($urandom_range(0, 31))) & ~16'h4;
         wr(a, d);
         pci_lvl = $urandom; obio_lvl = $urandom; isa_lvl = 16'($urandom);
         #1 check_vec("R6 random gating");
         if (it % 10 == 0) begin
            int k;
            k = int'($urandom_range(0, 31));
            rd_check("R3 onboard readback", oa(k), om[k]);
            rd_check("R2 pci readback", pa(k % 8), pm[k % 8]);
         end
      end

      // R6 disable one register and confirm its four vectors fall
      wr(pa(2), 32'h0);
      pci_lvl = '1;
      #1 check32("R6 disabled low", 32'(vec_req[11:8]), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule